// File: doc/BRIEF.md
# Cascadable BCD Divide-by-N Stage

This block is one decimal digit of a programmable down counter used for frequency division. It holds a single BCD digit. On each rising clock edge the digit counts down by one, unless it is being loaded from a 4-bit preset input or held by an inhibit input. An active-high clear input forces the digit to zero at once, without waiting for a clock edge.

A terminal-count flag, `zeroOut`, tells the stage that the coming counting edge would take the digit to zero. The flag passes through only while the chain input is high. To build a single-digit divider, tie `zeroOut` back to `loadEn` and hold `chainIn` high. The counter then runs N, N-1, ..., 1 and reloads N in place of entering zero, so the flag is high for one clock in every N clocks.

To divide by a multi-digit number, chain several stages:
- Each lower digit takes its `chainIn` from the flag of the digit above it.
- The top digit's `chainIn` is tied high.
- The least significant flag drives `loadEn` on every stage.
- Each upper digit is inhibited while the digit below it is non-zero.

Top module: `bcd_divider_stage`

## Requirements
- R1: While `clearAsync` is high, `countOut` is 0. The clear takes effect as soon as `clearAsync` rises, without a clock edge, and it overrides every other input.
- R2: With `loadEn` high at a rising edge, `countOut` takes the 4-bit `presetVal` after that edge. This holds for any value 0 to 15 and whatever the state of `clkHold`.
- R3: With `clkHold` high and `loadEn` low at a rising edge, `countOut` keeps its value.
- R4: With `loadEn` and `clkHold` both low, a count of 1 to 9 goes down by exactly one at the edge.
- R5: With `loadEn` and `clkHold` both low, a count of 0 becomes 9 at the edge.
- R6: With `loadEn` and `clkHold` both low, an out-of-range count of 10 to 15 becomes 9 at the edge. From there the normal decimal sequence follows.
- R7: `zeroOut` is combinational. It is high only when `chainIn` is high and one of these holds: `clkHold` is low with a count of 1, or `clkHold` is high with a count of 0. It is low in every other case.
- R8: In a single stage with `zeroOut` fed to `loadEn`, `chainIn` high, `clkHold` low and `presetVal` = N (1 to 9), `zeroOut` is high in exactly 3 of any 3N consecutive cycles once the loop has settled.
- R9: A two-stage chain is wired as follows:
  - upper `chainIn` is high;
  - lower `chainIn` is the upper `zeroOut`;
  - both `loadEn` inputs come from the lower `zeroOut`;
  - the upper `clkHold` is high while the lower count is non-zero.
  
  With presets giving 37 or 99, the lower `zeroOut` pulses 3 times in 3N cycles, and the combined count reads 01 on each pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock, rising edge |
| clearAsync | input | 1 | Asynchronous clear, active high |
| clkHold | input | 1 | Counting inhibit, active high |
| loadEn | input | 1 | Synchronous preset enable |
| presetVal | input | 4 | BCD value loaded when `loadEn` is high |
| chainIn | input | 1 | Cascade qualifier for `zeroOut` |
| countOut | output | 4 | Current BCD digit |
| zeroOut | output | 1 | Terminal-count flag, gated by `chainIn` |

## Verification
Timing of each result:
- A load, hold, step or wrap shows on `countOut` after the first rising edge that samples it. The bench drives inputs on falling edges and compares against its model 5 ns after each rising edge.
- `zeroOut` has no register on its path, so its decode checks are made 1 ns after the inputs change, within the same cycle.
- The asynchronous clear is checked 2 ns after `clearAsync` rises, before any clock edge.
- Divide ratios are checked by counting flag pulses over windows of whole periods. Each window opens only after a warm-up long enough for any earlier count to reach its reload.

// File: rtl/bcd_div_pkg.sv
package bcd_div_pkg;

  // Per-edge command from the control half to the digit register.
  typedef struct packed {
    logic loadNow;   // take the preset value
    logic stepNow;   // move one count down
  } digitCmd_t;

endpackage

// File: rtl/bcd_div_datapath.sv
module bcd_div_datapath
  import bcd_div_pkg::*;
#(
  parameter int DIGIT_W = 4,
  parameter int RADIX   = 10
) (
  input  logic               clk,
  input  logic               clearAsync,
  input  digitCmd_t          cmd,
  input  logic [DIGIT_W-1:0] loadVal,
  output logic [DIGIT_W-1:0] digit,
  output logic               atZero,
  output logic               atOne
);

  localparam int FULL_SPAN = 1 << DIGIT_W;

  logic [DIGIT_W-1:0] stepVal;

  // Down-step value: a full binary radix wraps naturally, otherwise
  // zero and any out-of-range code both fold to the top digit.
  generate
    if (RADIX == FULL_SPAN) begin : g_natWrap
      always_comb stepVal = digit - DIGIT_W'(1);
    end else begin : g_clampWrap
      localparam logic [DIGIT_W-1:0] TOP_DIGIT = DIGIT_W'(RADIX - 1);
      always_comb begin
        if (digit == '0 || digit > TOP_DIGIT) stepVal = TOP_DIGIT;
        else                                  stepVal = digit - DIGIT_W'(1);
      end
    end
  endgenerate

  always_ff @(posedge clk or posedge clearAsync) begin
    if (clearAsync)       digit <= '0;
    else if (cmd.loadNow) digit <= loadVal;
    else if (cmd.stepNow) digit <= stepVal;
  end

  always_comb begin
    atZero = (digit == '0);
    atOne  = (digit == DIGIT_W'(1));
  end

endmodule

// File: rtl/bcd_div_ctrl.sv
module bcd_div_ctrl
  import bcd_div_pkg::*;
(
  input  logic      loadEn,
  input  logic      clkHold,
  input  logic      chainIn,
  input  logic      atZero,
  input  logic      atOne,
  output digitCmd_t cmd,
  output logic      zeroOut
);

  logic nextIsZero;

  always_comb begin
    // Preset wins over the inhibit; the inhibit only stops stepping.
    cmd.loadNow = loadEn;
    cmd.stepNow = !loadEn && !clkHold;
    // Terminal count: the digit that the coming counting edge would reach.
    nextIsZero  = clkHold ? atZero : atOne;
    zeroOut     = chainIn && nextIsZero;
  end

endmodule

// File: rtl/bcd_divider_stage.sv
module bcd_divider_stage #(
  parameter int DIGIT_W = 4,
  parameter int RADIX   = 10
) (
  input  logic               clk,
  input  logic               clearAsync,
  input  logic               clkHold,
  input  logic               loadEn,
  input  logic [DIGIT_W-1:0] presetVal,
  input  logic               chainIn,
  output logic [DIGIT_W-1:0] countOut,
  output logic               zeroOut
);

  bcd_div_pkg::digitCmd_t cmd;
  logic atZero;
  logic atOne;

  bcd_div_ctrl u_ctrl (
    .loadEn  (loadEn),
    .clkHold (clkHold),
    .chainIn (chainIn),
    .atZero  (atZero),
    .atOne   (atOne),
    .cmd     (cmd),
    .zeroOut (zeroOut)
  );

  bcd_div_datapath #(
    .DIGIT_W (DIGIT_W),
    .RADIX   (RADIX)
  ) u_dp (
    .clk        (clk),
    .clearAsync (clearAsync),
    .cmd        (cmd),
    .loadVal    (presetVal),
    .digit      (countOut),
    .atZero     (atZero),
    .atOne      (atOne)
  );

endmodule

// File: rtl/bcd_divider_stage_chk.sv
module bcd_divider_stage_chk #(
  parameter int DIGIT_W = 4,
  parameter int RADIX   = 10
) (
  input logic               clk,
  input logic               clearAsync,
  input logic               clkHold,
  input logic               loadEn,
  input logic [DIGIT_W-1:0] presetVal,
  input logic               chainIn,
  input logic [DIGIT_W-1:0] countOut,
  input logic               zeroOut
);

  localparam logic [DIGIT_W-1:0] TOPV = DIGIT_W'(RADIX - 1);

  // R1: the digit is already clear at any edge seen while clear is high
  always @(posedge clk) begin
    if (clearAsync) begin
      p_async_clear_r1: assert (countOut == '0)
        else $error("clear did not force zero");
    end
  end

  p_load_r2: assert property (@(posedge clk) disable iff (clearAsync)
    loadEn |=> (countOut == $past(presetVal)));

  p_hold_r3: assert property (@(posedge clk) disable iff (clearAsync)
    (clkHold && !loadEn) |=> $stable(countOut));

  p_step_r4: assert property (@(posedge clk) disable iff (clearAsync)
    (!loadEn && !clkHold && countOut != '0 && countOut <= TOPV)
      |=> (countOut == $past(countOut) - DIGIT_W'(1)));

  p_wrap_r5: assert property (@(posedge clk) disable iff (clearAsync)
    (!loadEn && !clkHold && countOut == '0) |=> (countOut == TOPV));

  p_invalid_r6: assert property (@(posedge clk) disable iff (clearAsync)
    (!loadEn && !clkHold && countOut > TOPV) |=> (countOut == TOPV));

  p_zero_gate_r7: assert property (@(posedge clk) disable iff (clearAsync)
    zeroOut |-> (chainIn && countOut <= DIGIT_W'(1)));

endmodule

bind bcd_divider_stage bcd_divider_stage_chk #(
  .DIGIT_W (DIGIT_W),
  .RADIX   (RADIX)
) u_chk (
  .clk        (clk),
  .clearAsync (clearAsync),
  .clkHold    (clkHold),
  .loadEn     (loadEn),
  .presetVal  (presetVal),
  .chainIn    (chainIn),
  .countOut   (countOut),
  .zeroOut    (zeroOut)
);

// File: tb/sim_bcd_divider_stage.sv
`timescale 1ns/1ps
module sim_bcd_divider_stage;

  logic clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  logic       rst = 1'b0;
  logic       tbLoad = 1'b0, tbHold = 1'b0, tbChain = 1'b1, loopMode = 1'b0;
  logic [3:0] tbPreset = 4'd0;
  logic [3:0] u0Count;
  logic       u0Zero, u0Load;
  assign u0Load = loopMode ? u0Zero : tbLoad;

  bcd_divider_stage #(.DIGIT_W(4), .RADIX(10)) u0 (
    .clk(clk), .clearAsync(rst), .clkHold(tbHold), .loadEn(u0Load),
    .presetVal(tbPreset), .chainIn(tbChain), .countOut(u0Count), .zeroOut(u0Zero));

  // two-digit chain
  logic [3:0] hiPreset = 4'd3, loPreset = 4'd7, hiCount, loCount;
  logic       hiZero, loZero, hiHold;
  assign hiHold = (loCount != 4'd0);

  bcd_divider_stage #(.DIGIT_W(4), .RADIX(10)) uHi (
    .clk(clk), .clearAsync(rst), .clkHold(hiHold), .loadEn(loZero),
    .presetVal(hiPreset), .chainIn(1'b1), .countOut(hiCount), .zeroOut(hiZero));
  bcd_divider_stage #(.DIGIT_W(4), .RADIX(10)) uLo (
    .clk(clk), .clearAsync(rst), .clkHold(1'b0), .loadEn(loZero),
    .presetVal(loPreset), .chainIn(hiZero), .countOut(loCount), .zeroOut(loZero));

  int    checks = 0, errors = 0, cycles = 0;
  int    zeroHits = 0, loHits = 0;
  bit    cmpOn = 1'b0, done = 1'b0;
  string curReq = "R1";

  task automatic checkVal(input string req, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s got %0d expected %0d", req, what, got, exp);
    end
  endtask

  function automatic int modelZero(input int c, input logic h, input logic ch);
    return (ch && ((h && c == 0) || (!h && c == 1))) ? 1 : 0;
  endfunction

  // behavioural reference for u0, one update per rising edge
  int refCount = 0;
  always @(posedge clk or posedge rst) begin
    if (rst) refCount = 0;
    else begin
      int z;
      bit ld;
      z  = modelZero(refCount, tbHold, tbChain);
      ld = loopMode ? (z == 1) : tbLoad;
      if (ld)          refCount = int'(tbPreset);
      else if (!tbHold) refCount = (refCount == 0 || refCount > 9) ? 9 : refCount - 1;
    end
  end

  // compare every cycle, 5 ns after the edge
  always @(posedge clk) begin
    #5;
    if (cmpOn) begin
      checkVal(curReq, "count", int'(u0Count), refCount);
      checkVal(curReq, "zero", int'(u0Zero), modelZero(refCount, tbHold, tbChain));
      if (u0Zero) zeroHits++;
      if (loZero) begin
        loHits++;
        checkVal("R9", "chain value at pulse", int'(hiCount) * 10 + int'(loCount), 1);
      end
    end
  end

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      errors++;
      $display("FAIL watchdog run got timeout expected completion");
      summary();
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic loadDirect(input logic [3:0] v);
    tbPreset = v; tbLoad = 1'b1; cyc(1); tbLoad = 1'b0;
  endtask

  initial begin
    int keep;
    #1 rst = 1'b1;
    cmpOn = 1'b1;
    cyc(2);
    checkVal("R1", "reset count", int'(u0Count), 0);
    checkVal("R1", "reset zero", int'(u0Zero), 0);
    rst = 1'b0;

    // R2, R4, R5: load then count down through the wrap
    curReq = "R4";
    loadDirect(4'd5);
    checkVal("R2", "loaded count", int'(u0Count), 5);
    cyc(5);
    checkVal("R4", "after five steps", int'(u0Count), 0);
    curReq = "R5";
    cyc(1);
    checkVal("R5", "wrap", int'(u0Count), 9);
    cyc(2);

    // R3 hold, and R2 load during hold
    curReq = "R3";
    tbHold = 1'b1;
    keep = int'(u0Count);
    cyc(4);
    checkVal("R3", "held count", int'(u0Count), keep);
    curReq = "R2";
    loadDirect(4'd7);
    checkVal("R2", "load over hold", int'(u0Count), 7);
    cyc(1);
    checkVal("R3", "held after load", int'(u0Count), 7);
    tbHold = 1'b0;

    // R6 out-of-range digits
    curReq = "R6";
    loadDirect(4'd12);
    checkVal("R6", "raw load 12", int'(u0Count), 12);
    cyc(1);
    checkVal("R6", "12 steps to 9", int'(u0Count), 9);
    tbHold = 1'b1;
    loadDirect(4'd15);
    cyc(2);
    checkVal("R6", "15 held", int'(u0Count), 15);
    tbHold = 1'b0;
    cyc(1);
    checkVal("R6", "15 steps to 9", int'(u0Count), 9);
    cyc(1);
    checkVal("R6", "decimal after fold", int'(u0Count), 8);

    // R7 zero decode, checked within one cycle
    curReq = "R7";
    tbHold = 1'b1;
    loadDirect(4'd1);
    #1 checkVal("R7", "count1 held", int'(u0Zero), 0);
    tbHold = 1'b0;
    #1 checkVal("R7", "count1 running", int'(u0Zero), 1);
    tbChain = 1'b0;
    #1 checkVal("R7", "chain low", int'(u0Zero), 0);
    tbChain = 1'b1; tbHold = 1'b1;
    cyc(1);
    loadDirect(4'd0);
    #1 checkVal("R7", "count0 held", int'(u0Zero), 1);
    tbHold = 1'b0;
    #1 checkVal("R7", "count0 running", int'(u0Zero), 0);
    cyc(1);

    // R1 clear without a clock edge
    curReq = "R1";
    loadDirect(4'd8);
    #3 rst = 1'b1;
    #2 checkVal("R1", "async clear", int'(u0Count), 0);
    cyc(1);
    rst = 1'b0;
    cyc(1);

    // R8 single-stage divide ratios
    curReq = "R8";
    loopMode = 1'b1;
    for (int n = 1; n <= 9; n++) begin
      tbPreset = 4'(n);
      cyc(12);
      zeroHits = 0;
      cyc(3 * n);
      checkVal("R8", $sformatf("pulses for N=%0d", n), zeroHits, 3);
    end

    // R9 two-digit chain
    hiPreset = 4'd3; loPreset = 4'd7;
    cyc(120);
    loHits = 0;
    cyc(3 * 37);
    checkVal("R9", "pulses for 37", loHits, 3);
    hiPreset = 4'd9; loPreset = 4'd9;
    cyc(120);
    loHits = 0;
    cyc(3 * 99);
    checkVal("R9", "pulses for 99", loHits, 3);

    done = 1'b1;
    cmpOn = 1'b0;
    summary();
  end

endmodule